// File: doc/BRIEF.md
# Paged Configuration Register Bank with Signature Check

This block holds a chip's register space of 14-bit words behind a 9-bit address. The upper three address bits pick a page and the lower six pick a word in it. Page 2 holds the configuration words and a checksum word. Page 1 holds measurement results, which on-chip measurement logic fills, and a fault status word. An access with the read/write bit clear on page 3 is a command. Other pages read as zero.

A calculate command runs a 14-bit multiple-input signature register over the configuration words, one word per clock, and stores the result in the checksum word. A check command runs the same pass and compares the result with the stored word. On a mismatch a sticky parity fault is set, and the `halt` output tells the scanning and balancing logic to stop. While either pass runs, `busy` is high. Configuration writes and further commands are held off with `acc_ready` low, so the signature always covers a stable set of words.

Top module: `pagereg_misr`

## Requirements
- R1: After reset all configuration words, the checksum word, the measurement words and the fault status read zero, and `busy`, `halt` and `rd_valid` are low.
- R2: A write (`acc_wr`=1) to page 2 at offsets 0..N_CFG-1 stores the data ANDed with CFG_WMASK. By default this is 0x0FFF, so bits 13:12 are reserved and read 0. Offset N_CFG is the checksum word and keeps all 14 bits. A read (`acc_wr`=0) raises `rd_valid` with the value on `rd_data` in the cycle after it is accepted.
- R3: On page 1, offsets 0..N_MEAS-1 read the last value written through the `meas_*` port. Offset 0x3F reads the fault status, with the parity fault at bit 0. Host writes to page 1 change nothing.
- R4: Reads of pages 0 and 4..7, and of offsets with no register, return zero, and writes to them change nothing. A write (`acc_wr`=1) on page 3 is not a command.
- R5: A read access to page 3, offset 0, is the calculate command. It folds the configuration words from offset 0 upward into a signature. The signature starts from zero and each fold computes s' = (s<<1) ^ (s[13] ? 0x0443 : 0) ^ word, which is the polynomial x^14+x^10+x^6+x+1. The result is stored in the checksum word.
- R6: `busy` rises in the cycle after a command is accepted and stays high for exactly N_CFG+1 cycles.
- R7: A read access to page 3, offset 1, is the check command. It recomputes the signature. If the result differs from the stored checksum word, the parity fault and `halt` are set. A match leaves them unchanged.
- R8: The parity fault stays set through later matching checks. Only a completed calculate command or reset clears it.
- R9: While `busy` is high, page-2 writes and commands see `acc_ready` low and wait. Other accesses are accepted at once. The configuration words do not change during a pass.
- R10: When a host read and a measurement update hit the same page-1 word in the same cycle, the read returns the value held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access request |
| acc_ready | output | 1 | Access accepted this cycle when high |
| acc_wr | input | 1 | 1 = write, 0 = read or command |
| acc_page | input | 3 | Page select |
| acc_addr | input | 6 | Word offset within page |
| acc_wdata | input | 14 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 14 | Read data |
| meas_we | input | 1 | Measurement result write strobe |
| meas_idx | input | 6 | Measurement word index |
| meas_data | input | 14 | Measurement result value |
| cfg_bus | output | N_CFG*14 | All configuration words, word 0 in the low bits |
| busy | output | 1 | Signature pass running |
| halt | output | 1 | Parity fault: stop scanning and balancing |

## Verification
Two pairs of events can fall in the same cycle, and the bench provokes both. In the first, a configuration write arrives while a calculate pass is running. The write is held at `acc_ready` low until `busy` drops. The bench then confirms that the stored signature matches the words as they stood before the write, and that the write landed only afterwards. In the second, a measurement update and a host read of the same word are driven in one cycle. The read must return the old value, and a following read must return the new one. Random configuration contents and deliberate corruption of the checksum word are judged against a signature model in the bench.

// File: rtl/pagereg_misr_pkg.sv
package pagereg_misr_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_CALC  = 2'd1,
        OP_CHECK = 2'd2
    } sig_op_e;

    localparam logic [2:0] PG_MEAS = 3'd1;
    localparam logic [2:0] PG_CFG  = 3'd2;
    localparam logic [2:0] PG_CMD  = 3'd3;

    localparam logic [5:0] CMD_CALC  = 6'h00;
    localparam logic [5:0] CMD_CHECK = 6'h01;
    localparam logic [5:0] FLT_OFS   = 6'h3F;
    localparam int         PAR_BIT   = 0;

endpackage

// File: rtl/pagereg_misr_step.sv
module pagereg_misr_step #(
    parameter int             DW   = 14,
    parameter logic [DW-1:0]  TAPS = 14'h0443
) (
    input  logic [DW-1:0] sig_i,
    input  logic [DW-1:0] word_i,
    output logic [DW-1:0] sig_o
);
    // one Galois shift with feedback, then the parallel input is folded in
    always_comb begin
        sig_o = {sig_i[DW-2:0], 1'b0} ^ word_i;
        if (sig_i[DW-1]) begin
            sig_o = sig_o ^ TAPS;
        end
    end
endmodule

// File: rtl/pagereg_misr_cfg.sv
module pagereg_misr_cfg #(
    parameter int            DW    = 14,
    parameter int            NCFG  = 8,
    parameter int            IW    = 4,
    parameter logic [DW-1:0] WMASK = 14'h0FFF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_we,
    input  logic [IW-1:0]             host_idx,
    input  logic [DW-1:0]             host_data,
    input  logic                      sum_we,
    input  logic [DW-1:0]             sum_val,
    output logic [NCFG-1:0][DW-1:0]   cfg_o,
    output logic [DW-1:0]             sum_o
);
    typedef struct packed {
        logic [NCFG-1:0][DW-1:0] cfg;
        logic [DW-1:0]           sum;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (host_we) begin
            for (int i = 0; i < NCFG; i++) begin
                if (host_idx == IW'(i)) begin
                    bank_d.cfg[i] = host_data & WMASK;
                end
            end
            if (host_idx == IW'(NCFG)) begin
                bank_d.sum = host_data;
            end
        end
        if (sum_we) begin
            bank_d.sum = sum_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o = bank_q.cfg;
    assign sum_o = bank_q.sum;
endmodule

// File: rtl/pagereg_misr_meas.sv
module pagereg_misr_meas #(
    parameter int DW    = 14,
    parameter int NMEAS = 6,
    parameter int OW    = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [OW-1:0]            idx,
    input  logic [DW-1:0]            data,
    output logic [NMEAS-1:0][DW-1:0] meas_o
);
    logic [NMEAS-1:0][DW-1:0] meas_d, meas_q;

    always_comb begin
        meas_d = meas_q;
        for (int i = 0; i < NMEAS; i++) begin
            if (we && idx == OW'(i)) begin
                meas_d[i] = data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_q <= '0;
        end else begin
            meas_q <= meas_d;
        end
    end

    assign meas_o = meas_q;
endmodule

// File: rtl/pagereg_misr_seq.sv
module pagereg_misr_seq
    import pagereg_misr_pkg::*;
#(
    parameter int            DW   = 14,
    parameter int            NCFG = 8,
    parameter int            IW   = 4,
    parameter logic [DW-1:0] TAPS = 14'h0443
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_calc,
    input  logic          start_check,
    input  logic [DW-1:0] word_i,
    input  logic [DW-1:0] sum_i,
    output logic [IW-1:0] idx_o,
    output logic          busy_o,
    output logic          par_o,
    output logic          sum_we,
    output logic [DW-1:0] sum_val
);
    typedef struct packed {
        sig_op_e       op;
        logic [IW-1:0] idx;
        logic [DW-1:0] sig;
        logic          par;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [DW-1:0] sig_next;

    pagereg_misr_step #(.DW(DW), .TAPS(TAPS)) step_i (
        .sig_i  (seq_q.sig),
        .word_i (word_i),
        .sig_o  (sig_next)
    );

    always_comb begin
        seq_d   = seq_q;
        sum_we  = 1'b0;
        sum_val = seq_q.sig;
        if (seq_q.op == OP_NONE) begin
            if (start_calc || start_check) begin
                seq_d.op  = start_calc ? OP_CALC : OP_CHECK;
                seq_d.idx = '0;
                seq_d.sig = '0;
            end
        end else if (seq_q.idx == IW'(NCFG)) begin
            // closing cycle: every configuration word has been folded
            seq_d.op = OP_NONE;
            if (seq_q.op == OP_CALC) begin
                sum_we    = 1'b1;
                seq_d.par = 1'b0;
            end else begin
                seq_d.par = seq_q.par | (seq_q.sig != sum_i);
            end
        end else begin
            seq_d.sig = sig_next;
            seq_d.idx = seq_q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '{op: OP_NONE, idx: '0, sig: '0, par: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign idx_o  = seq_q.idx;
    assign busy_o = seq_q.op != OP_NONE;
    assign par_o  = seq_q.par;
endmodule

// File: rtl/pagereg_misr.sv
module pagereg_misr
    import pagereg_misr_pkg::*;
#(
    parameter int            DW        = 14,
    parameter int            PAGE_W    = 3,
    parameter int            OFS_W     = 6,
    parameter int            N_CFG     = 8,
    parameter int            N_MEAS    = 6,
    parameter logic [DW-1:0] CFG_WMASK = 14'h0FFF,
    parameter logic [DW-1:0] MISR_TAPS = 14'h0443
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  acc_valid,
    output logic                  acc_ready,
    input  logic                  acc_wr,
    input  logic [PAGE_W-1:0]     acc_page,
    input  logic [OFS_W-1:0]      acc_addr,
    input  logic [DW-1:0]         acc_wdata,
    output logic                  rd_valid,
    output logic [DW-1:0]         rd_data,
    input  logic                  meas_we,
    input  logic [OFS_W-1:0]      meas_idx,
    input  logic [DW-1:0]         meas_data,
    output logic [N_CFG*DW-1:0]   cfg_bus,
    output logic                  busy,
    output logic                  halt
);
    localparam int CIW = $clog2(N_CFG + 1);

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;

    logic [N_CFG-1:0][DW-1:0]  cfg_arr;
    logic [N_MEAS-1:0][DW-1:0] meas_arr;
    logic [DW-1:0]             sum_q, sum_val, fold_word, rd_mux;
    logic [CIW-1:0]            seq_idx;
    logic                      sum_we, par;
    logic                      pg_meas, pg_cfg, pg_cmd, cfg_slot, take;
    logic                      host_we, start_calc, start_check;

    assign pg_meas  = acc_page == PAGE_W'(PG_MEAS);
    assign pg_cfg   = acc_page == PAGE_W'(PG_CFG);
    assign pg_cmd   = acc_page == PAGE_W'(PG_CMD);
    assign cfg_slot = acc_addr <= OFS_W'(N_CFG);

    assign acc_ready   = !(busy && ((acc_wr && pg_cfg) || (!acc_wr && pg_cmd)));
    assign take        = acc_valid && acc_ready;
    assign host_we     = take && acc_wr && pg_cfg && cfg_slot;
    assign start_calc  = take && !acc_wr && pg_cmd && acc_addr == OFS_W'(CMD_CALC);
    assign start_check = take && !acc_wr && pg_cmd && acc_addr == OFS_W'(CMD_CHECK);

    pagereg_misr_cfg #(
        .DW(DW), .NCFG(N_CFG), .IW(CIW), .WMASK(CFG_WMASK)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_idx  (CIW'(acc_addr)),
        .host_data (acc_wdata),
        .sum_we    (sum_we),
        .sum_val   (sum_val),
        .cfg_o     (cfg_arr),
        .sum_o     (sum_q)
    );

    pagereg_misr_meas #(
        .DW(DW), .NMEAS(N_MEAS), .OW(OFS_W)
    ) meas_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (meas_we),
        .idx    (meas_idx),
        .data   (meas_data),
        .meas_o (meas_arr)
    );

    always_comb begin
        fold_word = '0;
        for (int i = 0; i < N_CFG; i++) begin
            if (seq_idx == CIW'(i)) begin
                fold_word = cfg_arr[i];
            end
        end
    end

    pagereg_misr_seq #(
        .DW(DW), .NCFG(N_CFG), .IW(CIW), .TAPS(MISR_TAPS)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_calc  (start_calc),
        .start_check (start_check),
        .word_i      (fold_word),
        .sum_i       (sum_q),
        .idx_o       (seq_idx),
        .busy_o      (busy),
        .par_o       (par),
        .sum_we      (sum_we),
        .sum_val     (sum_val)
    );

    always_comb begin
        rd_mux = '0;
        if (pg_meas) begin
            for (int i = 0; i < N_MEAS; i++) begin
                if (acc_addr == OFS_W'(i)) begin
                    rd_mux = meas_arr[i];
                end
            end
            if (acc_addr == OFS_W'(FLT_OFS)) begin
                rd_mux[PAR_BIT] = par;
            end
        end
        if (pg_cfg) begin
            for (int i = 0; i < N_CFG; i++) begin
                if (acc_addr == OFS_W'(i)) begin
                    rd_mux = cfg_arr[i];
                end
            end
            if (acc_addr == OFS_W'(N_CFG)) begin
                rd_mux = sum_q;
            end
        end
    end

    always_comb begin
        rd_d     = rd_q;
        rd_d.vld = take && !acc_wr && !pg_cmd;
        if (rd_d.vld) begin
            rd_d.data = rd_mux;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.vld;
    assign rd_data  = rd_q.data;
    assign cfg_bus  = cfg_arr;
    assign halt     = par;
endmodule

// File: rtl/pagereg_misr_chk.sv
module pagereg_misr_chk #(
    parameter int DW     = 14,
    parameter int PAGE_W = 3,
    parameter int OFS_W  = 6,
    parameter int N_CFG  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                acc_valid,
    input logic                acc_ready,
    input logic                acc_wr,
    input logic [PAGE_W-1:0]   acc_page,
    input logic                rd_valid,
    input logic [N_CFG*DW-1:0] cfg_bus,
    input logic                busy,
    input logic                halt
);
    // R9
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cfg_bus));

    // R9
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> acc_ready);

    // R6
    busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(acc_valid && acc_ready && !acc_wr && acc_page == PAGE_W'(3)));

    // R7
    par_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(busy));

    // R8
    par_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt) |-> $past(busy));

    // R2
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_valid && acc_ready && !acc_wr && acc_page != PAGE_W'(3)));
endmodule

bind pagereg_misr pagereg_misr_chk #(
    .DW(DW), .PAGE_W(PAGE_W), .OFS_W(OFS_W), .N_CFG(N_CFG)
) chk_i (.*);

// File: tb/pagereg_misr_tb_top.sv
module pagereg_misr_tb_top;
    localparam int DW = 14;
    localparam int NC = 8;
    localparam int NM = 6;
    localparam logic [DW-1:0] MASK = 14'h0FFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            acc_valid = 1'b0, acc_wr = 1'b0;
    logic            acc_ready;
    logic [2:0]      acc_page = '0;
    logic [5:0]      acc_addr = '0;
    logic [DW-1:0]   acc_wdata = '0;
    logic            rd_valid;
    logic [DW-1:0]   rd_data;
    logic            meas_we = 1'b0;
    logic [5:0]      meas_idx = '0;
    logic [DW-1:0]   meas_data = '0;
    logic [NC*DW-1:0] cfg_bus;
    logic            busy, halt;

    int total = 0;
    int bad = 0;

    logic [DW-1:0] shadow [NC];
    logic [DW-1:0] sum_m;
    logic          par_m;

    always #4 clk = ~clk;

    pagereg_misr dut_i (.*);

    function automatic logic [DW-1:0] fold(input logic [DW-1:0] s, input logic [DW-1:0] w);
        logic [DW-1:0] r;
        r = {s[DW-2:0], 1'b0} ^ w;
        if (s[DW-1]) r = r ^ 14'h0443;
        return r;
    endfunction

    function automatic logic [DW-1:0] sig_model();
        logic [DW-1:0] s = '0;
        for (int i = 0; i < NC; i++) s = fold(s, shadow[i]);
        return s;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic w, input logic [2:0] pg, input logic [5:0] ad, input logic [DW-1:0] d);
        acc_valid = 1'b1; acc_wr = w; acc_page = pg; acc_addr = ad; acc_wdata = d;
        #1;
        while (!acc_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rd(input logic [2:0] pg, input logic [5:0] ad, output logic [DW-1:0] v);
        put(1'b0, pg, ad, '0);
        v = rd_valid ? rd_data : 14'h3FFF;
    endtask

    task automatic cfg_wr(input int i, input logic [DW-1:0] d);
        put(1'b1, 3'd2, 6'(i), d);
        if (i < NC) shadow[i] = d & MASK;
        else if (i == NC) sum_m = d;
    endtask

    task automatic cmd(input logic [5:0] ad, output int cyc);
        put(1'b0, 3'd3, ad, '0);
        cyc = 0;
        while (busy) begin
            cyc++;
            @(negedge clk);
        end
        if (ad == 6'h00) begin
            sum_m = sig_model();
            par_m = 1'b0;
        end else begin
            par_m = par_m | (sig_model() != sum_m);
        end
    endtask

    task automatic cfg_match(input string req);
        for (int i = 0; i < NC; i++) check(req, cfg_bus[i*DW +: DW], shadow[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] v;
        int cyc;
        void'($urandom(32'd2718));
        for (int i = 0; i < NC; i++) shadow[i] = '0;
        sum_m = '0;
        par_m = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 halt", halt, 0);
        check("R1 rd_valid", rd_valid, 0);
        rd(3'd2, 6'd0, v);     check("R1 cfg0", v, 0);
        rd(3'd2, 6'(NC), v);   check("R1 sum", v, 0);
        rd(3'd1, 6'd0, v);     check("R1 meas0", v, 0);
        rd(3'd1, 6'h3F, v);    check("R1 fault", v, 0);

        // R2 masking and checksum word width
        cfg_wr(0, 14'h3FFF);
        rd(3'd2, 6'd0, v);     check("R2 masked", v, 14'h0FFF);
        cfg_wr(NC, 14'h3ABC);
        rd(3'd2, 6'(NC), v);   check("R2 sum full", v, 14'h3ABC);
        cfg_match("R2 cfg_bus");

        // R3 measurement path, host writes ignored
        @(negedge clk);
        meas_we = 1'b1; meas_idx = 6'd3; meas_data = 14'h2D5A;
        @(negedge clk);
        meas_we = 1'b0;
        rd(3'd1, 6'd3, v);     check("R3 meas", v, 14'h2D5A);
        put(1'b1, 3'd1, 6'd3, 14'h0001);
        rd(3'd1, 6'd3, v);     check("R3 host wr ignored", v, 14'h2D5A);

        // R4 unused space
        put(1'b1, 3'd0, 6'd0, 14'h0155);
        put(1'b1, 3'd2, 6'd20, 14'h0155);
        put(1'b1, 3'd5, 6'd1, 14'h0155);
        cfg_match("R4 no side write");
        rd(3'd0, 6'd0, v);     check("R4 page0", v, 0);
        rd(3'd2, 6'd20, v);    check("R4 gap", v, 0);
        put(1'b1, 3'd3, 6'd0, 14'h0000);
        check("R4 page3 write no cmd", busy, 0);

        // R5 / R6 calculate
        for (int i = 0; i < NC; i++) cfg_wr(i, 14'(i * 14'h0321 + 14'h0047));
        cmd(6'h00, cyc);
        check("R6 busy length", cyc, NC + 1);
        rd(3'd2, 6'(NC), v);   check("R5 signature", v, sig_model());

        // R7 matching check, then mismatch
        cmd(6'h01, cyc);
        check("R7 match halt", halt, 0);
        cfg_wr(2, shadow[2] ^ 14'h0010);
        cmd(6'h01, cyc);
        check("R7 mismatch halt", halt, 1);
        rd(3'd1, 6'h3F, v);    check("R7 fault bit0", v, 1);

        // R8 sticky, cleared by calculate
        cfg_wr(2, shadow[2] ^ 14'h0010);
        cmd(6'h01, cyc);
        check("R8 sticky", halt, 1);
        cmd(6'h00, cyc);
        check("R8 cleared", halt, 0);

        // R9 write during calculate is held, lands afterwards
        acc_valid = 1'b1; acc_wr = 1'b0; acc_page = 3'd3; acc_addr = 6'h00;
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = 1'b0; acc_page = 3'd1; acc_addr = 6'd3;
        #1;
        check("R9 read not held", acc_ready, 1);
        acc_wr = 1'b1; acc_page = 3'd2; acc_addr = 6'd1; acc_wdata = 14'h0ABC;
        #1;
        check("R9 cfg write held", acc_ready, 0);
        check("R9 busy", busy, 1);
        sum_m = sig_model();
        while (!acc_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        acc_valid = 1'b0;
        shadow[1] = 14'h0ABC;
        rd(3'd2, 6'(NC), v);   check("R9 sum of old words", v, sum_m);
        cfg_match("R9 late write");

        // R10 read and update of one word in one cycle
        meas_we = 1'b1; meas_idx = 6'd3; meas_data = 14'h1111;
        acc_valid = 1'b1; acc_wr = 1'b0; acc_page = 3'd1; acc_addr = 6'd3;
        @(negedge clk);
        meas_we = 1'b0; acc_valid = 1'b0;
        check("R10 old value", rd_data, 14'h2D5A);
        rd(3'd1, 6'd3, v);     check("R10 new value", v, 14'h1111);

        // random configurations, calculate, optional corruption, check
        for (int t = 0; t < 16; t++) begin
            for (int k = 0; k < 3; k++) cfg_wr($urandom_range(0, NC - 1), 14'($urandom));
            cmd(6'h00, cyc);
            rd(3'd2, 6'(NC), v);   check("R5 random sig", v, sum_m);
            check("R8 calc clears", halt, 0);
            if ($urandom_range(0, 1) == 1) begin
                if ($urandom_range(0, 1) == 1) cfg_wr(NC, sum_m ^ 14'(1 << $urandom_range(0, 13)));
                else cfg_wr(0, shadow[0] ^ 14'h0001);
            end
            cmd(6'h01, cyc);
            check("R7 random check", halt, par_m);
            cfg_match("R2 random words");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule